// File: doc/BRIEF.md
# Frame Sync Format Detector and Bit Timing Unit

This unit sits in front of a time-slot switching core. It watches the frame pulse line of a serial backplane whose bit clock runs at 4.096 MHz. From the pulse alone it works out which framing convention is in use. In the ST-BUS convention the frame pulse is a short low excursion on an otherwise high line. In the GCI convention it is a short high excursion on an otherwise low line. Once two pulses of the same kind arrive exactly one frame apart, the unit declares lock. It then gives the switching core a frame start strobe, the channel and bit position, a shift strobe at each bit boundary and a sample strobe three quarters of the way into each bit cell.

The unit runs from one rising-edge clock `clk` at twice the serial clock rate. The serial clock `ser_clk_i` is sampled in that domain, so every `clk` cycle is either a rising or a falling serial edge. Two serial clocks make one bit cell, which is four `clk` ticks, and a frame is 32 channels of 8 bits. For ST-BUS the bit boundary sits on a falling serial edge. For GCI it sits on a rising serial edge. In both cases the sample point is the third tick after the boundary.

A state machine controls lock. It has three states: SEARCH, VERIFY and LOCKED.
- SEARCH moves to VERIFY on any valid pulse (*start*).
- VERIFY moves to LOCKED when a pulse arrives with the same format and a spacing of 512 serial clocks (*confirm*).
- VERIFY stays in VERIFY on any other pulse, restarting from that pulse (*restart*).
- LOCKED stays in LOCKED on a matching pulse (*hold*).
- LOCKED falls back to VERIFY on a pulse with the wrong format or spacing (*slip*).
- VERIFY or LOCKED returns to SEARCH after 520 serial clocks with no pulse (*timeout*).

Top module: `fsync_timing`

## Requirements
- R1: A low level lasting 1 or 2 serial clocks, after a high run of at least 3, is a pulse of ST-BUS format. `fmt_gci_o` reads 0 after it.
- R2: A high level lasting 1 or 2 serial clocks, after a low run of at least 3, is a pulse of GCI format. `fmt_gci_o` reads 1 after it.
- R3: A run of 3 or more serial clocks at either level is never taken as a pulse. A stream of such runs never raises `locked_o` and never changes `fmt_gci_o` from its reset value 0.
- R4: After the serial rising edge that samples the end of a second pulse, `locked_o` rises in the second `clk` cycle. That pulse must have the same format as the first and end exactly 512 serial clocks after it. One pulse alone never sets lock.
- R5: While locked, a pulse whose spacing from the previous pulse is not 512 serial clocks, or whose format differs, clears `locked_o` in the second cycle after its end is sampled. The next correctly spaced pulse locks again.
- R6: If 520 serial clocks pass after the last pulse with no new pulse, `locked_o` clears. With the sample cycle of the last pulse's end called P, `locked_o` is still 1 at cycle P+1040 and 0 at P+1042.
- R7: With lock held, `frame_start_o` is high for exactly one cycle in every 1024. It comes 2 cycles after the pulse-end sample in ST-BUS (a falling-edge boundary) and 3 cycles after it in GCI (a rising-edge boundary).
- R8: With t counting cycles from frame start (0 to 1023), `chan_o` equals t/32 and `bit_o` equals (t/4) mod 8.
- R9: `shift_o` is high when t mod 4 is 0 (the bit boundary). `sample_o` is high when t mod 4 is 3 (three quarters of the way into the cell). Both strobes, and `frame_start_o`, stay 0 while unlocked.
- R10: Reset clears the state. `locked_o`, `fmt_gci_o`, `chan_o`, `bit_o` and all strobes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial backplane clock, sampled by `clk` |
| fpulse_i | input | 1 | Frame pulse line, either polarity |
| fmt_gci_o | output | 1 | Detected format: 0 ST-BUS, 1 GCI |
| locked_o | output | 1 | Frame timing confirmed |
| frame_start_o | output | 1 | First tick of a frame |
| chan_o | output | 5 | Channel number 0 to 31 |
| bit_o | output | 3 | Bit index within the channel, 0 to 7 |
| sample_o | output | 1 | Sample strobe at three quarters of the bit cell |
| shift_o | output | 1 | Shift strobe at the bit boundary |

## Verification
The assertions check the following on every cycle:
- a pulse report always follows a rising serial edge;
- the silence counter never passes its limit;
- entry to LOCKED is always caused by a pulse, and exit to SEARCH only by timeout;
- the format does not change while lock is held;
- a realignment while locked lands exactly on the natural frame wrap;
- every frame start follows channel 31, bit 7.

Only the bench scenarios can show the rest:
- the exact cycle at which lock appears, drops or times out;
- the one-cycle shift in boundary between the two formats;
- that wide runs are rejected;
- that channel, bit and strobe values match the arithmetic at every tick of a frame.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    typedef enum logic [1:0] {
        S_SEARCH = 2'd0,
        S_VERIFY = 2'd1,
        S_LOCKED = 2'd2
    } lock_state_e;

    typedef enum logic {
        FMT_STBUS = 1'b0,
        FMT_GCI   = 1'b1
    } sync_fmt_e;

endpackage

// File: rtl/fts_pulse_classifier.sv
module fts_pulse_classifier
    import fsync_pkg::*;
#(
    parameter int MAX_PULSE = 2
)
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ser_clk_i,
    input  logic      fp_i,
    output logic      rise_ev_o,
    output logic      fall_ev_o,
    output logic      pulse_v_o,
    output sync_fmt_e pulse_fmt_o
);
    localparam int LW = $clog2(MAX_PULSE + 2);
    localparam logic [LW-1:0] LONG_RUN = LW'(MAX_PULSE + 1);

    logic          sclk_q;
    logic          sclk_qq;
    logic          fp_q;
    logic          run_lvl;
    logic [LW-1:0] run_len;
    logic          prev_long;

    assign rise_ev_o =  sclk_q & ~sclk_qq;
    assign fall_ev_o = ~sclk_q &  sclk_qq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q      <= 1'b0;
            sclk_qq     <= 1'b0;
            fp_q        <= 1'b0;
            run_lvl     <= 1'b0;
            run_len     <= '0;
            prev_long   <= 1'b0;
            pulse_v_o   <= 1'b0;
            pulse_fmt_o <= FMT_STBUS;
        end else begin
            sclk_q    <= ser_clk_i;
            sclk_qq   <= sclk_q;
            fp_q      <= fp_i;
            pulse_v_o <= 1'b0;
            if (rise_ev_o) begin
                if (fp_q == run_lvl) begin
                    if (run_len != LONG_RUN) begin
                        run_len <= run_len + 1'b1;
                    end
                end else begin
                    pulse_v_o   <= prev_long && (run_len <= LW'(MAX_PULSE));
                    pulse_fmt_o <= run_lvl ? FMT_GCI : FMT_STBUS;
                    prev_long   <= (run_len == LONG_RUN);
                    run_lvl     <= fp_q;
                    run_len     <= LW'(1);
                end
            end
        end
    end

    // R1
    pulse_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_v_o |-> $past(rise_ev_o));

endmodule

// File: rtl/fts_lock_fsm.sv
module fts_lock_fsm
    import fsync_pkg::*;
#(
    parameter int FRAME_SCLK = 512,
    parameter int TIMEOUT    = 520
)
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rise_ev_i,
    input  logic      pulse_v_i,
    input  sync_fmt_e pulse_fmt_i,
    output logic      locked_o,
    output sync_fmt_e fmt_o
);
    localparam int GW = $clog2(TIMEOUT + 1);

    lock_state_e   state;
    lock_state_e   state_nx;
    logic [GW-1:0] gap;
    sync_fmt_e     fmt_q;
    logic          match;
    logic          expired;

    assign match   = (pulse_fmt_i == fmt_q) && (gap == GW'(FRAME_SCLK));
    assign expired = (gap == GW'(TIMEOUT));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_SEARCH: begin
                if (pulse_v_i) state_nx = S_VERIFY;
            end
            S_VERIFY: begin
                if (pulse_v_i)    state_nx = match ? S_LOCKED : S_VERIFY;
                else if (expired) state_nx = S_SEARCH;
            end
            S_LOCKED: begin
                if (pulse_v_i)    state_nx = match ? S_LOCKED : S_VERIFY;
                else if (expired) state_nx = S_SEARCH;
            end
            default: state_nx = S_SEARCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_SEARCH;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap   <= '0;
            fmt_q <= FMT_STBUS;
        end else if (pulse_v_i) begin
            gap   <= '0;
            fmt_q <= pulse_fmt_i;
        end else if (rise_ev_i && !expired) begin
            gap <= gap + 1'b1;
        end
    end

    always_comb begin
        locked_o = (state == S_LOCKED);
        fmt_o    = fmt_q;
    end

    // R6
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= GW'(TIMEOUT));

    // R4
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOCKED && $past(state) != S_LOCKED) |-> $past(pulse_v_i));

    // R6
    timeout_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SEARCH && $past(state) != S_SEARCH) |-> $past(expired));

    // R5
    fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && $past(locked_o)) |-> $stable(fmt_o));

endmodule

// File: rtl/fts_bit_timer.sv
module fts_bit_timer
    import fsync_pkg::*;
#(
    parameter int CHANNELS    = 32,
    parameter int BITS_PER_CH = 8
)
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rise_ev_i,
    input  logic                           fall_ev_i,
    input  logic                           pulse_v_i,
    input  sync_fmt_e                      pulse_fmt_i,
    input  logic                           locked_i,
    output logic                           frame_start_o,
    output logic [$clog2(CHANNELS)-1:0]    chan_o,
    output logic [$clog2(BITS_PER_CH)-1:0] bit_o,
    output logic                           sample_o,
    output logic                           shift_o
);
    localparam int TICKS_PER_BIT = 4;
    localparam int PW    = $clog2(TICKS_PER_BIT);
    localparam int BW    = $clog2(BITS_PER_CH);
    localparam int CW    = $clog2(CHANNELS);
    localparam int TICKS = CHANNELS * BITS_PER_CH * TICKS_PER_BIT;
    localparam int TW    = $clog2(TICKS);

    logic [TW-1:0] tk;
    logic          pending;
    sync_fmt_e     pend_fmt;
    logic          load_now;
    logic          load_pend;

    assign load_now  = pulse_v_i && ((pulse_fmt_i == FMT_STBUS) ? fall_ev_i : rise_ev_i);
    assign load_pend = pending   && ((pend_fmt    == FMT_STBUS) ? fall_ev_i : rise_ev_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tk       <= '0;
            pending  <= 1'b0;
            pend_fmt <= FMT_STBUS;
        end else if (load_now || load_pend) begin
            tk      <= '0;
            pending <= 1'b0;
        end else begin
            tk <= (tk == TW'(TICKS - 1)) ? '0 : tk + 1'b1;
            if (pulse_v_i) begin
                pending  <= 1'b1;
                pend_fmt <= pulse_fmt_i;
            end
        end
    end

    always_comb begin
        frame_start_o = locked_i && (tk == '0);
        chan_o        = tk[TW-1 -: CW];
        bit_o         = tk[PW +: BW];
        shift_o       = locked_i && (tk[PW-1:0] == '0);
        sample_o      = locked_i && (tk[PW-1:0] == PW'(TICKS_PER_BIT - 1));
    end

    // R7
    realign_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_i && $past(locked_i) && tk == '0) |-> $past(tk) == TW'(TICKS - 1));

    // R9
    sample_then_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> (shift_o || !locked_i));

endmodule

// File: rtl/fsync_timing.sv
module fsync_timing
    import fsync_pkg::*;
#(
    parameter int CHANNELS    = 32,
    parameter int BITS_PER_CH = 8,
    parameter int MAX_PULSE   = 2,
    parameter int TIMEOUT     = 520
)
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ser_clk_i,
    input  logic                           fpulse_i,
    output logic                           fmt_gci_o,
    output logic                           locked_o,
    output logic                           frame_start_o,
    output logic [$clog2(CHANNELS)-1:0]    chan_o,
    output logic [$clog2(BITS_PER_CH)-1:0] bit_o,
    output logic                           sample_o,
    output logic                           shift_o
);
    localparam int FRAME_SCLK = CHANNELS * BITS_PER_CH * 2;
    localparam int CW = $clog2(CHANNELS);
    localparam int BW = $clog2(BITS_PER_CH);

    logic      rise_ev;
    logic      fall_ev;
    logic      pulse_v;
    sync_fmt_e pulse_fmt;
    sync_fmt_e fmt;

    fts_pulse_classifier #(.MAX_PULSE(MAX_PULSE)) u_classify (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk_i   (ser_clk_i),
        .fp_i        (fpulse_i),
        .rise_ev_o   (rise_ev),
        .fall_ev_o   (fall_ev),
        .pulse_v_o   (pulse_v),
        .pulse_fmt_o (pulse_fmt)
    );

    fts_lock_fsm #(.FRAME_SCLK(FRAME_SCLK), .TIMEOUT(TIMEOUT)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_ev_i   (rise_ev),
        .pulse_v_i   (pulse_v),
        .pulse_fmt_i (pulse_fmt),
        .locked_o    (locked_o),
        .fmt_o       (fmt)
    );

    fts_bit_timer #(.CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .rise_ev_i     (rise_ev),
        .fall_ev_i     (fall_ev),
        .pulse_v_i     (pulse_v),
        .pulse_fmt_i   (pulse_fmt),
        .locked_i      (locked_o),
        .frame_start_o (frame_start_o),
        .chan_o        (chan_o),
        .bit_o         (bit_o),
        .sample_o      (sample_o),
        .shift_o       (shift_o)
    );

    assign fmt_gci_o = (fmt == FMT_GCI);

    // R8
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o && $past(locked_o)) |->
            ($past(chan_o) == CW'(CHANNELS - 1) && $past(bit_o) == BW'(BITS_PER_CH - 1)));

endmodule

// File: tb/test_fsync_timing.sv
module test_fsync_timing;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       fpulse = 1'b1;
    logic       fmt_gci, locked, frame_start, sample, shift;
    logic [4:0] chan;
    logic [2:0] bitn;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int last_end = 0;
    int exp_fs = 0;
    int prev = 0;
    bit sweep = 1'b0;

    fsync_timing i_fsync_timing (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .fpulse_i(fpulse),
        .fmt_gci_o(fmt_gci), .locked_o(locked), .frame_start_o(frame_start),
        .chan_o(chan), .bit_o(bitn), .sample_o(sample), .shift_o(shift)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // one serial clock period: low half then high half
    task automatic sclock(input logic lvl, input bit mark);
        @(negedge clk);
        ser_clk = 1'b0;
        fpulse  = lvl;
        @(negedge clk);
        ser_clk = 1'b1;
        if (mark) last_end = cyc + 1;
    endtask

    task automatic frame(input bit gci, input int w, input int len);
        for (int p = 0; p < len; p++) sclock((p < w) ? gci : ~gci, p == w);
    endtask

    task automatic idle(input bit gci, input int n);
        for (int p = 0; p < n; p++) sclock(~gci, 1'b0);
    endtask

    task automatic at_off(input int old, input int off);
        wait (last_end != old);
        while (cyc < last_end + off) @(negedge clk);
    endtask

    // exhaustive per-tick sweep of one locked frame (R7, R8, R9)
    always @(negedge clk) begin
        int t;
        if (sweep && cyc >= exp_fs) begin
            t = (cyc - exp_fs) % 1024;
            chk(frame_start == (t == 0), "R7", frame_start, t == 0);
            chk(int'(chan) == t / 32, "R8", chan, t / 32);
            chk(int'(bitn) == (t / 4) % 8, "R8", bitn, (t / 4) % 8);
            chk(shift == (t % 4 == 0), "R9", shift, t % 4 == 0);
            chk(sample == (t % 4 == 3), "R9", sample, t % 4 == 3);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R4: watchdog expired, actual cycle %0d expected finish", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(1'b0, 3);
        // R10 reset state
        chk(locked == 0, "R10", locked, 0);
        chk(fmt_gci == 0, "R10", fmt_gci, 0);
        chk(chan == 0 && bitn == 0, "R10", {chan, bitn}, 0);
        chk({frame_start, sample, shift} == 0, "R10", {frame_start, sample, shift}, 0);
        rst_n = 1'b1;
        idle(1'b0, 8);

        // ST-BUS, 1-clock low pulse: first pulse alone does not lock
        prev = last_end;
        fork
            frame(1'b0, 1, 512);
            begin
                at_off(prev, 2);
                chk(locked == 0, "R4", locked, 0);
                chk(fmt_gci == 0, "R1", fmt_gci, 0);
            end
        join
        prev = last_end;
        fork
            frame(1'b0, 1, 512);
            begin
                at_off(prev, 1);
                chk(locked == 0, "R4", locked, 0);
                at_off(prev, 2);
                chk(locked == 1, "R4", locked, 1);
                chk(frame_start == 1, "R7", frame_start, 1);
                chk(fmt_gci == 0, "R1", fmt_gci, 0);
            end
        join
        exp_fs = last_end + 2;
        sweep = 1'b1;
        frame(1'b0, 1, 512);
        sweep = 1'b0;

        // R5: early pulse drops lock, next good spacing relocks
        frame(1'b0, 1, 500);
        prev = last_end;
        fork
            frame(1'b0, 1, 512);
            begin
                at_off(prev, 2);
                chk(locked == 0, "R5", locked, 0);
            end
        join
        prev = last_end;
        fork
            frame(1'b0, 1, 512);
            begin
                at_off(prev, 2);
                chk(locked == 1, "R5", locked, 1);
            end
        join

        // R6: silence after last pulse
        prev = last_end;
        fork
            begin
                frame(1'b0, 1, 512);
                idle(1'b0, 200);
            end
            begin
                at_off(prev, 1040);
                chk(locked == 1, "R6", locked, 1);
                at_off(prev, 1042);
                chk(locked == 0, "R6", locked, 0);
                chk({frame_start, sample, shift} == 0, "R9", {frame_start, sample, shift}, 0);
            end
        join

        // R10 reset mid-run, then R3 wide high runs on a low line
        rst_n = 1'b0;
        idle(1'b1, 3);
        chk(locked == 0 && fmt_gci == 0, "R10", {locked, fmt_gci}, 0);
        chk(chan == 0 && bitn == 0, "R10", {chan, bitn}, 0);
        rst_n = 1'b1;
        idle(1'b1, 8);
        frame(1'b1, 3, 512);
        frame(1'b1, 3, 512);
        frame(1'b1, 3, 512);
        chk(locked == 0, "R3", locked, 0);
        chk(fmt_gci == 0, "R3", fmt_gci, 0);

        // GCI, 2-clock high pulse
        prev = last_end;
        fork
            frame(1'b1, 2, 512);
            begin
                at_off(prev, 2);
                chk(fmt_gci == 1, "R2", fmt_gci, 1);
                chk(locked == 0, "R4", locked, 0);
            end
        join
        prev = last_end;
        fork
            frame(1'b1, 2, 512);
            begin
                at_off(prev, 2);
                chk(locked == 1, "R4", locked, 1);
                chk(frame_start == 0, "R7", frame_start, 0);
                at_off(prev, 3);
                chk(frame_start == 1, "R7", frame_start, 1);
                chk(fmt_gci == 1, "R2", fmt_gci, 1);
            end
        join
        exp_fs = last_end + 3;
        sweep = 1'b1;
        frame(1'b1, 2, 512);
        sweep = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule